// File: doc/BRIEF.md
# Stack Calculator Entry and Evaluation Controller

This block sits between a keyboard decoder and a result display. Decimal digit keys build an unsigned operand of up to four digits. Operator keys arm an operator. A latch strobe commits the pending entry, either the operand or the operator, into an 8-bit-wide single-port RAM. The RAM is used as a stack: entries go to the next free address, counting up from 0. Operators share the RAM with operands and are told apart by reserved byte codes.

Each Enter pops one whole expression from the top of the stack, evaluates it and presents a signed result with a sign flag and an overflow flag. An expression is either operand, operator, operand, or operand followed by the modulo-3 operator. Entries may be pushed again after some pops, so later Enters evaluate the newest expressions first. A pop that finds too few entries, or entries in the wrong shape, raises a one-cycle error and leaves the stack as it was.

The controller is a six-state machine:
- IDLE: entry and pushes happen here.
- TOP: presents the top-of-stack address.
- GET1: the top byte arrives from the RAM.
- GET2: the second byte arrives.
- GET3: the third byte arrives, for binary operators only.
- EXEC: registers the result.

The transitions are:
- IDLE→TOP on Enter with a non-empty stack.
- TOP→GET1 unconditionally.
- GET1→GET2 when the top byte and the stack depth are consistent.
- GET2→EXEC for modulo 3.
- GET2→GET3 for a binary operator.
- GET3→EXEC when the bottom byte is an operand.
- EXEC→IDLE unconditionally.
- Every failed consistency check returns to IDLE with an error.

The RAM returns read data one cycle after the address is presented.

Top module: `calc_stack_ctrl`

## Requirements
- R1: Digit keys with a value from 0 to 9 accumulate a decimal number, most significant digit first. At most four digits are held, and further digits and values above 9 are ignored. A latch with fewer than three digits pending writes nothing.
- R2: A pending operand whose stored value would fall in 130..135 is not written on latch. The digits stay pending so that they can be edited.
- R3: A pending operand above 255 is written as 255.
- R4: Backspace removes the last pending digit. With no digits pending, it cancels an armed operator. A successful latch clears the pending entry.
- R5: op_sel 0, 1, 2 and 3 select add, subtract, multiply and modulo 3. These are stored as bytes 130, 131, 132 and 133. With no digits pending, a latch writes the armed operator's byte. Every write goes to address sp, which starts at 0 and then increments by one. While idle, mem_addr shows sp.
- R6: Enter pops the top expression. If the top byte is 133, one operand is popped below it and sp drops by 2. Otherwise the pop reads operand B (top), then the operator, then operand A, and sp drops by 3.
- R7: The result is A+B, A-B, A*B or A mod 3, given as RES_W-bit two's complement. res_neg is set exactly when the result is negative. res_valid pulses for one cycle.
- R8: res_ovf is set when the result magnitude exceeds 999.
- R9: An Enter on an empty stack, on too few entries, or on a malformed expression pulses pop_err. sp is left unchanged.
- R10: Pushes made after pops land at the current sp, and the next Enter evaluates them first.
- R11: Latch and Enter are ignored while an evaluation is running. Latch has priority over Enter in the same idle cycle.
- R12: With all 2^ADDR_W entries in use, a latch writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| digit_valid | input | 1 | Digit key strobe |
| digit_val | input | 4 | Digit value |
| op_valid | input | 1 | Operator key strobe |
| op_sel | input | 2 | Operator: 0 add, 1 sub, 2 mul, 3 mod 3 |
| bksp | input | 1 | Backspace strobe |
| latch | input | 1 | Commit pending entry to the stack |
| enter | input | 1 | Pop and evaluate one expression |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle latency |
| res_valid | output | 1 | Result strobe |
| res_value | output | RES_W | Signed result |
| res_neg | output | 1 | Result is negative |
| res_ovf | output | 1 | Result magnitude above 999 |
| pop_err | output | 1 | Pop rejected |

## Verification
A wrong stack pointer appears at once on mem_addr while the block is idle. It also shows up on the next Enter as a result built from the wrong bytes or as a spurious pop_err, within six cycles. A fault in the entry register shows in the byte written at the latch edge, so each push is checked against the RAM model one cycle later. A wrong decode in the pop states shows on res_value or pop_err within the five cycles of a pop. Those checks use expressions that exercise operator order, sign, overflow at 999 and 1000, reserved codes, saturation, interleaved pushes and a full stack.

// File: rtl/calc_pkg.sv
package calc_pkg;
    localparam logic [7:0] CODE_LO  = 8'd130;
    localparam logic [7:0] CODE_MUL = 8'd132;
    localparam logic [7:0] CODE_MOD = 8'd133;
    localparam logic [7:0] CODE_HI  = 8'd135;
    localparam int         SHOW_MAX = 999;

    typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_MUL, OP_MOD} op_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TOP, ST_GET1, ST_GET2, ST_GET3, ST_EXEC
    } pop_state_t;

    function automatic logic is_code(input logic [7:0] b);
        return (b >= CODE_LO) && (b <= CODE_HI);
    endfunction
endpackage

// File: rtl/calc_entry.sv
module calc_entry
    import calc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       digit_valid,
    input  logic [3:0] digit_val,
    input  logic       op_valid,
    input  logic [1:0] op_sel,
    input  logic       bksp,
    input  logic       ack,
    output logic       commit_ok,
    output logic [7:0] commit_byte
);
    localparam int ACC_W   = 14;
    localparam int MAX_DIG = 4;

    logic [ACC_W-1:0] acc;
    logic [2:0]       ndig;
    logic             op_pend;
    logic [1:0]       op_hold;
    logic [7:0]       clamped;

    always_comb begin
        clamped     = (acc > ACC_W'(255)) ? 8'd255 : acc[7:0];
        commit_ok   = ((ndig >= 3'd3) && !is_code(clamped)) || ((ndig == 3'd0) && op_pend);
        commit_byte = (ndig != 3'd0) ? clamped : (CODE_LO + {6'd0, op_hold});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            ndig    <= '0;
            op_pend <= 1'b0;
            op_hold <= '0;
        end else if (ack) begin
            if (ndig != 3'd0) begin
                acc  <= '0;
                ndig <= '0;
            end else begin
                op_pend <= 1'b0;
            end
        end else if (bksp) begin
            if (ndig != 3'd0) begin
                acc  <= ACC_W'(acc / ACC_W'(10));
                ndig <= ndig - 3'd1;
            end else begin
                op_pend <= 1'b0;
            end
        end else if (digit_valid && (ndig < 3'(MAX_DIG)) && (digit_val <= 4'd9)) begin
            acc  <= ACC_W'(acc * ACC_W'(10)) + ACC_W'(digit_val);
            ndig <= ndig + 3'd1;
        end else if (op_valid && (ndig == 3'd0)) begin
            op_pend <= 1'b1;
            op_hold <= op_sel;
        end
    end

    AST_DIGIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ndig <= 3'(MAX_DIG)); // R1
    AST_BKSP_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bksp && !ack && ndig != 3'd0) |=> ndig == $past(ndig) - 3'd1); // R4
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ndig != 3'd0) |=> (ndig == 3'd0 && acc == '0)); // R4
endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
#(
    parameter int RES_W = 18
) (
    input  logic [7:0]              a,
    input  logic [7:0]              b,
    input  op_t                     op,
    output logic signed [RES_W-1:0] value,
    output logic                    neg,
    output logic                    ovf
);
    logic signed [RES_W-1:0] mag;

    always_comb begin
        unique case (op)
            OP_ADD:  value = RES_W'(a) + RES_W'(b);
            OP_SUB:  value = RES_W'(a) - RES_W'(b);
            OP_MUL:  value = RES_W'(a) * RES_W'(b);
            default: value = RES_W'(a % 8'd3);
        endcase
        neg = value[RES_W-1];
        mag = neg ? -value : value;
        ovf = mag > RES_W'(SHOW_MAX);
    end
endmodule

// File: rtl/calc_stack_ctrl.sv
module calc_stack_ctrl
    import calc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int RES_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              digit_valid,
    input  logic [3:0]        digit_val,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic              bksp,
    input  logic              latch,
    input  logic              enter,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_value,
    output logic              res_neg,
    output logic              res_ovf,
    output logic              pop_err
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SP_W  = ADDR_W + 1;

    pop_state_t              state, nxt;
    logic [SP_W-1:0]         sp, addr_full;
    logic [7:0]              top_q, opa, opb;
    op_t                     op_q;
    logic                    commit_ok;
    logic [7:0]              commit_byte;
    logic                    start, top_ok, arith_ok, rd_operand;
    logic [7:0]              rd_delta;
    logic signed [RES_W-1:0] alu_value;
    logic                    alu_neg, alu_ovf;

    calc_entry u_entry (
        .clk(clk), .rst_n(rst_n), .digit_valid(digit_valid), .digit_val(digit_val),
        .op_valid(op_valid), .op_sel(op_sel), .bksp(bksp), .ack(mem_we),
        .commit_ok(commit_ok), .commit_byte(commit_byte)
    );

    calc_alu #(.RES_W(RES_W)) u_alu (
        .a(opa), .b(opb), .op(op_q), .value(alu_value), .neg(alu_neg), .ovf(alu_ovf)
    );

    always_comb begin
        mem_we     = latch && commit_ok && (state == ST_IDLE) && (sp < SP_W'(DEPTH));
        mem_wdata  = commit_byte;
        start      = (state == ST_IDLE) && enter && !latch;
        rd_operand = !is_code(mem_rdata);
        rd_delta   = mem_rdata - CODE_LO;
        arith_ok   = (mem_rdata >= CODE_LO) && (mem_rdata <= CODE_MUL);
        top_ok     = ((mem_rdata == CODE_MOD) && (sp >= SP_W'(2)))
                   || (rd_operand && (sp >= SP_W'(3)));
        unique case (state)
            ST_TOP:  addr_full = sp - SP_W'(1);
            ST_GET1: addr_full = sp - SP_W'(2);
            ST_GET2: addr_full = sp - SP_W'(3);
            default: addr_full = sp;
        endcase
        mem_addr = addr_full[ADDR_W-1:0];
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start && sp != '0) nxt = ST_TOP;
            ST_TOP:  nxt = ST_GET1;
            ST_GET1: nxt = top_ok ? ST_GET2 : ST_IDLE;
            ST_GET2: begin
                if (top_q == CODE_MOD) nxt = rd_operand ? ST_EXEC : ST_IDLE;
                else                   nxt = arith_ok ? ST_GET3 : ST_IDLE;
            end
            ST_GET3: nxt = rd_operand ? ST_EXEC : ST_IDLE;
            ST_EXEC: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp        <= '0;
            top_q     <= '0;
            opa       <= '0;
            opb       <= '0;
            op_q      <= OP_ADD;
            res_value <= '0;
            res_neg   <= 1'b0;
            res_ovf   <= 1'b0;
            res_valid <= 1'b0;
            pop_err   <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            pop_err   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (mem_we)                 sp <= sp + SP_W'(1);
                    else if (start && sp == '0) pop_err <= 1'b1;
                end
                ST_GET1: begin
                    top_q <= mem_rdata;
                    if (!top_ok) pop_err <= 1'b1;
                end
                ST_GET2: begin
                    if (top_q == CODE_MOD) begin
                        opa  <= mem_rdata;
                        op_q <= OP_MOD;
                        if (rd_operand) sp <= sp - SP_W'(2);
                        else            pop_err <= 1'b1;
                    end else begin
                        opb  <= top_q;
                        op_q <= op_t'(rd_delta[1:0]);
                        if (!arith_ok) pop_err <= 1'b1;
                    end
                end
                ST_GET3: begin
                    opa <= mem_rdata;
                    if (rd_operand) sp <= sp - SP_W'(3);
                    else            pop_err <= 1'b1;
                end
                ST_EXEC: begin
                    res_value <= alu_value;
                    res_neg   <= alu_neg;
                    res_ovf   <= alu_ovf;
                    res_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R5
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !mem_we); // R11
    AST_ERR_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        pop_err |-> $stable(sp)); // R9
    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_MOD) |-> (!res_neg && res_value < RES_W'(3))); // R7
    AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(DEPTH)); // R12
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && pop_err)); // R9
endmodule

// File: tb/calc_stack_ctrl_test.sv
module calc_stack_ctrl_test;
    localparam int AW = 4;
    localparam int RW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          digit_valid = 0, op_valid = 0, bksp = 0, latch = 0, enter = 0;
    logic [3:0]    digit_val = '0;
    logic [1:0]    op_sel = '0;
    logic          mem_we, res_valid, res_neg, res_ovf, pop_err;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic [RW-1:0] res_value;
    logic [7:0]    ram [1<<AW];
    int            wr_cnt = 0;
    int            checks = 0, failures = 0;
    int            exp_sp = 0;

    always #10ns clk = ~clk;

    calc_stack_ctrl #(.ADDR_W(AW), .RES_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .digit_valid(digit_valid), .digit_val(digit_val),
        .op_valid(op_valid), .op_sel(op_sel), .bksp(bksp), .latch(latch), .enter(enter),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_value(res_value), .res_neg(res_neg), .res_ovf(res_ovf),
        .pop_err(pop_err)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            wr_cnt        <= wr_cnt + 1;
        end
        mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        exp_sp = 0;
        @(negedge clk);
    endtask

    task automatic key_digit(input int d);
        digit_val = 4'(d); digit_valid = 1'b1;
        @(negedge clk); digit_valid = 1'b0;
    endtask

    task automatic key_op(input int o);
        op_sel = 2'(o); op_valid = 1'b1;
        @(negedge clk); op_valid = 1'b0;
    endtask

    task automatic key_bksp();
        bksp = 1'b1; @(negedge clk); bksp = 1'b0;
    endtask

    task automatic key_latch();
        latch = 1'b1; @(negedge clk); latch = 1'b0;
    endtask

    task automatic type3(input int v);
        key_digit(v / 100); key_digit((v / 10) % 10); key_digit(v % 10);
    endtask

    task automatic push_num(input int v, input string req);
        int w0;
        w0 = wr_cnt;
        type3(v); key_latch();
        chk(req, wr_cnt - w0, 1);
        chk(req, int'(ram[AW'(exp_sp)]), v);
        exp_sp++;
    endtask

    task automatic push_op(input int o);
        key_op(o); key_latch();
        chk("R5", int'(ram[AW'(exp_sp)]), 130 + o);
        exp_sp++;
        chk("R5", int'(mem_addr), exp_sp % (1 << AW));
    endtask

    task automatic do_enter(input string req, input bit exp_err, input int v,
                            input bit neg, input bit ovf, input int pops);
        bit got_res = 0, got_err = 0;
        int val = 0;
        bit n = 0, o = 0;
        enter = 1'b1; @(negedge clk); enter = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (res_valid) begin got_res = 1; val = int'($signed(res_value)); n = res_neg; o = res_ovf; end
            if (pop_err) got_err = 1;
            @(negedge clk);
        end
        chk({req, " err"}, int'(got_err), int'(exp_err));
        chk({req, " valid"}, int'(got_res), int'(!exp_err));
        if (!exp_err) begin
            chk({req, " value"}, val, v);
            chk({req, " sign"}, int'(n), int'(neg));
            chk("R8 ovf", int'(o), int'(ovf));
            exp_sp -= pops;
        end
        chk("R6 depth", int'(mem_addr), exp_sp % (1 << AW));
    endtask

    task automatic t_reset();
        chk("R5 reset we", int'(mem_we), 0);
        chk("R5 reset addr", int'(mem_addr), 0);
        chk("R7 reset valid", int'(res_valid), 0);
        chk("R9 reset err", int'(pop_err), 0);
    endtask

    task automatic t_empty();
        do_enter("R9 empty", 1, 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        push_num(98, "R5"); push_op(0); push_num(10, "R5");
        do_enter("R6 R7 add", 0, 108, 0, 0, 3);
    endtask

    task automatic t_interleave();
        push_num(3, "R5"); push_op(2); push_num(54, "R5");
        push_num(6, "R5"); push_op(1); push_num(30, "R5");
        do_enter("R7 sub", 0, -24, 1, 0, 3);
        push_num(7, "R10"); push_op(2); push_num(7, "R10");
        do_enter("R10 newest", 0, 49, 0, 0, 3);
        do_enter("R10 older", 0, 162, 0, 0, 3);
    endtask

    task automatic t_overflow();
        push_num(255, "R5"); push_op(2); push_num(255, "R5");
        do_enter("R8 big", 0, 65025, 0, 1, 3);
        push_num(37, "R5"); push_op(2); push_num(27, "R5");
        do_enter("R8 999", 0, 999, 0, 0, 3);
        push_num(100, "R5"); push_op(2); push_num(10, "R5");
        do_enter("R8 1000", 0, 1000, 0, 1, 3);
        push_num(0, "R5"); push_op(1); push_num(255, "R5");
        do_enter("R7 neg", 0, -255, 1, 0, 3);
    endtask

    task automatic t_saturate_mod();
        int w0;
        w0 = wr_cnt;
        key_digit(1); key_digit(2); key_digit(3); key_digit(4); key_latch();
        chk("R3 write", wr_cnt - w0, 1);
        chk("R3 sat", int'(ram[AW'(exp_sp)]), 255);
        exp_sp++;
        push_op(3);
        do_enter("R6 mod 255", 0, 0, 0, 0, 2);
        push_num(13, "R5"); push_op(3);
        do_enter("R6 mod 13", 0, 1, 0, 0, 2);
    endtask

    task automatic t_reserved();
        int w0;
        w0 = wr_cnt;
        type3(132); key_latch();
        chk("R2 rejected", wr_cnt - w0, 0);
        key_bksp(); key_digit(6); key_latch();
        chk("R2 kept digits", wr_cnt - w0, 1);
        chk("R2 edited", int'(ram[AW'(exp_sp)]), 136);
        exp_sp++;
        do_enter("R9 short", 1, 0, 0, 0, 0);
    endtask

    task automatic t_backspace();
        int w0;
        w0 = wr_cnt;
        key_digit(1); key_digit(2); key_bksp(); key_digit(5); key_latch();
        chk("R1 two digits", wr_cnt - w0, 0);
        key_digit(0); key_latch();
        chk("R4 write", wr_cnt - w0, 1);
        chk("R4 value", int'(ram[AW'(exp_sp)]), 150);
        exp_sp++;
        key_op(0); key_bksp(); key_latch();
        chk("R4 op cancel", wr_cnt - w0, 1);
    endtask

    task automatic t_digit_cap();
        int w0;
        w0 = wr_cnt;
        key_digit(0); key_digit(0); key_digit(1); key_digit(2); key_digit(3);
        key_digit(11); key_latch();
        chk("R1 cap write", wr_cnt - w0, 1);
        chk("R1 cap value", int'(ram[AW'(exp_sp)]), 12);
        exp_sp++;
        do_enter("R9 malformed", 1, 0, 0, 0, 0);
    endtask

    task automatic t_busy();
        int nres = 0;
        int w0;
        do_reset();
        push_num(2, "R5"); push_op(0); push_num(3, "R5");
        push_num(4, "R5"); push_op(0); push_num(5, "R5");
        w0 = wr_cnt;
        enter = 1'b1; @(negedge clk); @(negedge clk); enter = 1'b0;
        digit_val = 4'd9; digit_valid = 1'b1; @(negedge clk); digit_valid = 1'b0;
        latch = 1'b1; @(negedge clk); latch = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (res_valid) begin
                nres++;
                chk("R11 value", int'($signed(res_value)), 9);
            end
            @(negedge clk);
        end
        chk("R11 one result", nres, 1);
        chk("R11 no write", wr_cnt - w0, 0);
        chk("R11 depth", int'(mem_addr), 3);
        key_bksp();
        w0 = wr_cnt;
        type3(1); latch = 1'b1; enter = 1'b1; @(negedge clk); latch = 1'b0; enter = 1'b0;
        nres = 0;
        for (int i = 0; i < 12; i++) begin
            if (res_valid || pop_err) nres++;
            @(negedge clk);
        end
        chk("R11 latch wins", wr_cnt - w0, 1);
        chk("R11 enter dropped", nres, 0);
        chk("R11 addr", int'(mem_addr), 4);
    endtask

    task automatic t_full();
        int w0;
        do_reset();
        for (int k = 0; k < (1 << AW); k++) push_num(k + 1, "R12");
        chk("R12 addr wrap", int'(mem_addr), 0);
        w0 = wr_cnt;
        type3(17); key_latch();
        chk("R12 full", wr_cnt - w0, 0);
        chk("R12 intact", int'(ram[0]), 1);
    endtask

    initial begin
        for (int k = 0; k < (1 << AW); k++) ram[k] = '0;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_basic();
        t_interleave();
        t_overflow();
        t_saturate_mod();
        t_reserved();
        t_backspace();
        t_digit_cap();
        t_busy();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20ns * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule